// File: doc/BRIEF.md
# Bus Clock Prescaler and Gating

This block turns one main clock into four synchronous clock domains: processor, high-speed bus, peripheral bus A and peripheral bus B. The main clock comes from one of two sources, an oscillator or a PLL. Each source is modelled as a per-cycle enable input, and a control bit picks which one is used. Each domain has its own power-of-two prescaler. The prescaler produces a one-cycle enable pulse at the domain's rate rather than a derived clock net. Each domain also has a 32-bit gating mask, and the pulse is spread through that mask into per-module clock enables.

Software programs the block through a plain 32-bit register port. The port has a synchronous write strobe and a read path that is combinational on the address. Software changes one module's clock by reading a mask, setting or clearing one bit, and writing the mask back. One module enable belongs to the peripheral block that contains this controller, so it can never be turned off.

Top module: `bclk_ctrl`

## Requirements
- R1: After reset, the word at offset 0x00 reads 0 and the word at 0x04 reads 0. The four mask words at 0x08, 0x0C, 0x10 and 0x14 read 0xFFFFFFFF. The oscillator is the main source.
- R2: Bit 1 of the word at 0x00 selects the main clock source: 0 selects `osc0_tick` and 1 selects `pll0_tick`. Once written, the bit reads back, and the other source has no effect on any output.
- R3: The word at 0x04 holds four 8-bit fields, one per domain. The processor field is byte 0, the high-speed bus byte 1, peripheral bus A byte 2 and peripheral bus B byte 3. In each field, bits [2:0] are the divider selector and bit 7 is the divide enable. When the divide enable is 0, the domain's `dom_tick` bit equals the main tick in every cycle.
- R4: When the divide enable is 1 and the selector is S, `dom_tick` gives exactly one single-cycle pulse for every 2^(S+1) main ticks.
- R5: A new selector or divide-enable value takes effect only at the next terminal count of the setting in use. The period already under way therefore completes at its old length.
- R6: The mask words at 0x08 to 0x14 belong to the processor, high-speed bus, peripheral bus A and peripheral bus B domains, in that order. `mod_ce[d*32+n]` is 1 exactly when `dom_tick[d]` is 1 and bit n of domain d's mask is 1.
- R7: Bit 0 of the peripheral bus B mask, which is the controller's own module, always reads 1, whatever value is written. Its enable therefore follows that domain's pulse.
- R8: Offsets that hold no register read 0, and writes to them change no register. Bits of 0x00 and 0x04 that hold no field read 0.
- R9: A mask word reads back the value last written, so a read-modify-write of one bit leaves the other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc0_tick | input | 1 | Oscillator source enable, one bit per cycle |
| pll0_tick | input | 1 | PLL source enable, one bit per cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wdata | input | DATA_W (32) | Register write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` |
| dom_tick | output | 4 | Per-domain enable pulse; bit 0 processor, 1 high-speed bus, 2 bus A, 3 bus B |
| mod_ce | output | 4*MASK_W (128) | Per-module clock enables, domain d in bits [d*32+31:d*32] |

## Verification
The situation hardest to bring about from the ports is a selector write that lands in the middle of a long divided period. The write must arrive after the period has begun, so that an early load would show up as a short gap between pulses. To reach it, the stimulus first sets the slowest setting, waits until a processor pulse appears, and writes a fast setting in the next cycle. It then measures the two following gaps between pulses, which must be 256 cycles and then 2. Throughout the run, a behavioural model of counters and masks predicts every output in every cycle, under random source enables.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

   // Number of clock domains fixed by the packed select word layout
   localparam int NUM_DOM      = 4;

   // Word indices (byte offset divided by four)
   localparam int WORD_MAIN    = 0;
   localparam int WORD_PRESC   = 1;
   localparam int WORD_MASK0   = 2;

   // Bit of the main control word choosing the PLL as source
   localparam int SRC_BIT      = 1;

   // Packed select word: one byte per domain, divide enable at the top of it
   localparam int FIELD_STRIDE = 8;
   localparam int DIVEN_OFS    = 7;

   typedef enum logic [1:0] {
      DOM_CPU = 2'd0,
      DOM_HSB = 2'd1,
      DOM_PBA = 2'd2,
      DOM_PBB = 2'd3
   } dom_e;

endpackage

// File: rtl/bclk_presc.sv
module bclk_presc #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             main_tick,
   input  logic             cfg_div,
   input  logic [SEL_W-1:0] cfg_sel,
   output logic             tick
);
   // Largest divide is 2^(2^SEL_W), so the counter needs 2^SEL_W bits
   localparam int CNT_W = 2 ** SEL_W;

   logic             act_div_q;
   logic [SEL_W-1:0] act_sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;
   logic [SEL_W-1:0] shamt;
   logic             at_term;

   // Terminal value is 2^(sel+1)-1 when dividing, else 0 (every main tick)
   assign shamt   = SEL_W'(CNT_W - 1) - act_sel_q;
   assign term    = act_div_q ? ({CNT_W{1'b1}} >> shamt) : '0;
   assign at_term = (cnt_q == term);
   assign tick    = main_tick & at_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         act_div_q <= 1'b0;
         act_sel_q <= '0;
      end else if (main_tick) begin
         if (at_term) begin
            cnt_q     <= '0;
            act_div_q <= cfg_div;
            act_sel_q <= cfg_sel;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/bclk_regs.sv
module bclk_regs
   import bclk_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int MASK_W   = 32,
   parameter int SEL_W    = 3,
   parameter int NDOM     = 4,
   parameter int SELF_DOM = 3,
   parameter int SELF_IDX = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      wdata,
   output logic [DATA_W-1:0]      rdata,
   output logic                   main_sel,
   output logic [NDOM-1:0]        div_en,
   output logic [NDOM*SEL_W-1:0]  div_sel,
   output logic [NDOM*MASK_W-1:0] mask
);
   localparam int WIDX_W = ADDR_W - 2;

   logic [WIDX_W-1:0]      widx;
   logic                   unused_low;
   logic                   hit_main;
   logic                   hit_presc;
   logic [NDOM-1:0]        hit_mask;
   logic                   main_sel_q;
   logic [NDOM-1:0]        div_en_q;
   logic [NDOM*SEL_W-1:0]  div_sel_q;
   logic [NDOM*MASK_W-1:0] mask_q;

   assign widx       = addr[ADDR_W-1:2];
   assign unused_low = ^addr[1:0];
   assign hit_main   = (widx == WIDX_W'(WORD_MAIN));
   assign hit_presc  = (widx == WIDX_W'(WORD_PRESC));

   // Main source select
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   main_sel_q <= 1'b0;
      else if (wr_en && hit_main)   main_sel_q <= wdata[SRC_BIT];
   end

   // Packed prescaler select word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_en_q  <= '0;
         div_sel_q <= '0;
      end else if (wr_en && hit_presc) begin
         for (int d = 0; d < NDOM; d++) begin
            div_en_q[d]                  <= wdata[d*FIELD_STRIDE + DIVEN_OFS];
            div_sel_q[d*SEL_W +: SEL_W]  <= wdata[d*FIELD_STRIDE +: SEL_W];
         end
      end
   end

   // Per-domain gating masks; the controller's own domain keeps one bit pinned
   for (genvar d = 0; d < NDOM; d++) begin : g_mask
      logic [MASK_W-1:0] next_val;

      assign hit_mask[d] = (widx == WIDX_W'(WORD_MASK0 + d));

      if (d == SELF_DOM) begin : g_pinned
         localparam logic [MASK_W-1:0] PIN = MASK_W'(1) << SELF_IDX;
         assign next_val = wdata[MASK_W-1:0] | PIN;
      end else begin : g_free
         assign next_val = wdata[MASK_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   mask_q[d*MASK_W +: MASK_W] <= '1;
         else if (wr_en && hit_mask[d]) mask_q[d*MASK_W +: MASK_W] <= next_val;
      end
   end

   // Read mux; unused words and unused bits return zero
   always_comb begin
      rdata = '0;
      if (hit_main) begin
         rdata[SRC_BIT] = main_sel_q;
      end else if (hit_presc) begin
         for (int d = 0; d < NDOM; d++) begin
            rdata[d*FIELD_STRIDE +: SEL_W]        = div_sel_q[d*SEL_W +: SEL_W];
            rdata[d*FIELD_STRIDE + DIVEN_OFS]     = div_en_q[d];
         end
      end else begin
         for (int d = 0; d < NDOM; d++) begin
            if (hit_mask[d]) rdata[MASK_W-1:0] = mask_q[d*MASK_W +: MASK_W];
         end
      end
   end

   assign main_sel = main_sel_q;
   assign div_en   = div_en_q;
   assign div_sel  = div_sel_q;
   assign mask     = mask_q;

endmodule

// File: rtl/bclk_gate.sv
module bclk_gate #(
   parameter int NDOM   = 4,
   parameter int MASK_W = 32
) (
   input  logic [NDOM-1:0]        tick,
   input  logic [NDOM*MASK_W-1:0] mask,
   output logic [NDOM*MASK_W-1:0] ce
);
   for (genvar d = 0; d < NDOM; d++) begin : g_dom
      assign ce[d*MASK_W +: MASK_W] = mask[d*MASK_W +: MASK_W] & {MASK_W{tick[d]}};
   end
endmodule

// File: rtl/bclk_ctrl.sv
module bclk_ctrl
   import bclk_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int MASK_W   = 32,
   parameter int SEL_W    = 3,
   parameter int SELF_DOM = 3,
   parameter int SELF_IDX = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      osc0_tick,
   input  logic                      pll0_tick,
   input  logic                      bus_wr,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic [DATA_W-1:0]         bus_rdata,
   output logic [NUM_DOM-1:0]        dom_tick,
   output logic [NUM_DOM*MASK_W-1:0] mod_ce
);
   // Elaboration-time parameter checks
   if (DATA_W < NUM_DOM * FIELD_STRIDE) begin : g_bad_data
      $error("DATA_W too narrow for the packed select word");
   end
   if (MASK_W > DATA_W || MASK_W < 1) begin : g_bad_mask
      $error("MASK_W must lie in 1..DATA_W");
   end
   if (SEL_W < 1 || SEL_W > 5 || SEL_W > DIVEN_OFS) begin : g_bad_sel
      $error("SEL_W must lie in 1..5");
   end
   if (SELF_DOM < 0 || SELF_DOM >= NUM_DOM || SELF_IDX < 0 || SELF_IDX >= MASK_W) begin : g_bad_self
      $error("pinned module out of range");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic                      main_sel;
   logic                      main_tick;
   logic [NUM_DOM-1:0]        div_en;
   logic [NUM_DOM*SEL_W-1:0]  div_sel;
   logic [NUM_DOM*MASK_W-1:0] mask;

   bclk_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .MASK_W   (MASK_W),
      .SEL_W    (SEL_W),
      .NDOM     (NUM_DOM),
      .SELF_DOM (SELF_DOM),
      .SELF_IDX (SELF_IDX)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .rdata    (bus_rdata),
      .main_sel (main_sel),
      .div_en   (div_en),
      .div_sel  (div_sel),
      .mask     (mask)
   );

   assign main_tick = main_sel ? pll0_tick : osc0_tick;

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_presc
      bclk_presc #(
         .SEL_W (SEL_W)
      ) u_presc (
         .clk       (clk),
         .rst_n     (rst_n),
         .main_tick (main_tick),
         .cfg_div   (div_en[d]),
         .cfg_sel   (div_sel[d*SEL_W +: SEL_W]),
         .tick      (dom_tick[d])
      );
   end

   bclk_gate #(
      .NDOM   (NUM_DOM),
      .MASK_W (MASK_W)
   ) u_gate (
      .tick (dom_tick),
      .mask (mask),
      .ce   (mod_ce)
   );

endmodule

// File: rtl/bclk_ctrl_chk.sv
module bclk_ctrl_chk
   import bclk_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int MASK_W   = 32,
   parameter int SELF_DOM = 3,
   parameter int SELF_IDX = 0
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      osc0_tick,
   input logic                      pll0_tick,
   input logic                      main_sel,
   input logic                      bus_wr,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic [DATA_W-1:0]         bus_wdata,
   input logic [DATA_W-1:0]         bus_rdata,
   input logic [NUM_DOM-1:0]        dom_tick,
   input logic [NUM_DOM*MASK_W-1:0] mod_ce
);
   localparam int WIDX_W = ADDR_W - 2;
   logic [WIDX_W-1:0] widx;
   logic              unused_chk;

   assign widx       = bus_addr[ADDR_W-1:2];
   assign unused_chk = ^{bus_addr[1:0], bus_wdata};

   AST_SRC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && widx == WIDX_W'(WORD_MAIN)) |=> (main_sel == $past(bus_wdata[SRC_BIT]))); // R2

   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (widx > WIDX_W'(WORD_MASK0 + NUM_DOM - 1)) |-> (bus_rdata == '0)); // R8

   AST_SELF_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
      dom_tick[SELF_DOM] |-> mod_ce[SELF_DOM*MASK_W + SELF_IDX]); // R7

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      AST_TICK_ON_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
         dom_tick[d] |-> (main_sel ? pll0_tick : osc0_tick)); // R4

      AST_CE_WITHIN_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         (mod_ce[d*MASK_W +: MASK_W] != '0) |-> dom_tick[d]); // R6
   end

endmodule

bind bclk_ctrl bclk_ctrl_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .MASK_W   (MASK_W),
   .SELF_DOM (SELF_DOM),
   .SELF_IDX (SELF_IDX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .osc0_tick (osc0_tick),
   .pll0_tick (pll0_tick),
   .main_sel  (main_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .dom_tick  (dom_tick),
   .mod_ce    (mod_ce)
);

// File: tb/bclk_ctrl_tb.sv
module bclk_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ND = 4;
   localparam int MW = 32;

   logic           clk       = 1'b0;
   logic           rst_n     = 1'b0;
   logic           osc0_tick = 1'b0;
   logic           pll0_tick = 1'b0;
   logic           bus_wr    = 1'b0;
   logic [7:0]     bus_addr  = '0;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic [ND-1:0]  dom_tick;
   logic [ND*MW-1:0] mod_ce;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Behavioural reference state
   int          m_src;
   int          m_div[ND];
   int          m_sel[ND];
   int          m_act_div[ND];
   int          m_act_sel[ND];
   int          m_cnt[ND];
   logic [31:0] m_mask[ND];
   int          tick_cnt[ND];
   int          last_tick[ND];
   int          gap[ND];
   int          cyc = 0;
   int          n0;

   bclk_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .osc0_tick (osc0_tick),
      .pll0_tick (pll0_tick),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .dom_tick  (dom_tick),
      .mod_ce    (mod_ce)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int m_term(input int d);
      if (m_act_div[d] != 0) return (1 << (m_act_sel[d] + 1)) - 1;
      return 0;
   endfunction

   function automatic logic m_main();
      return (m_src != 0) ? pll0_tick : osc0_tick;
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      logic [31:0] v;
      v = '0;
      case (a[7:2])
         6'd0: v[1] = m_src[0];
         6'd1: for (int k = 0; k < ND; k++) begin
                  v[k*8 +: 3] = m_sel[k][2:0];
                  v[k*8 + 7]  = m_div[k][0];
               end
         6'd2, 6'd3, 6'd4, 6'd5: v = m_mask[int'(a[7:2]) - 2];
         default: v = '0;
      endcase
      return v;
   endfunction

   // One cycle: drive after the falling edge, compare, then advance the model
   task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic o, input logic p);
      logic [ND-1:0]    et;
      logic [ND*MW-1:0] ece;
      logic             mt;
      bus_wr = wr; bus_addr = a; bus_wdata = d; osc0_tick = o; pll0_tick = p;
      #1;
      mt = m_main();
      for (int k = 0; k < ND; k++) begin
         et[k] = mt && (m_cnt[k] == m_term(k));
         ece[k*MW +: MW] = et[k] ? m_mask[k] : '0;
      end
      chk("R3 R4 R5 domain pulse", 128'(dom_tick), 128'(et));
      chk("R6 module enables", 128'(mod_ce), 128'(ece));
      chk("R8 R9 register read", 128'(bus_rdata), 128'(m_read(a)));
      for (int k = 0; k < ND; k++) begin
         if (dom_tick[k]) begin
            tick_cnt[k]++;
            gap[k] = cyc - last_tick[k];
            last_tick[k] = cyc;
         end
      end
      @(posedge clk);
      for (int k = 0; k < ND; k++) begin
         if (mt) begin
            if (m_cnt[k] == m_term(k)) begin
               m_cnt[k]     = 0;
               m_act_div[k] = m_div[k];
               m_act_sel[k] = m_sel[k];
            end else begin
               m_cnt[k]++;
            end
         end
      end
      if (wr) begin
         case (a[7:2])
            6'd0: m_src = int'(d[1]);
            6'd1: for (int k = 0; k < ND; k++) begin
                     m_div[k] = int'(d[k*8 + 7]);
                     m_sel[k] = int'(d[k*8 +: 3]);
                  end
            6'd2, 6'd3, 6'd4, 6'd5: m_mask[int'(a[7:2]) - 2] = d;
            default: ;
         endcase
         m_mask[3][0] = 1'b1;
      end
      cyc++;
      @(negedge clk);
   endtask

   task automatic pre(input logic o, input logic p, input logic [7:0] a);
      bus_wr = 1'b0; bus_addr = a; osc0_tick = o; pll0_tick = p;
      #1;
   endtask

   task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input string tag);
      pre(1'b0, 1'b0, a);
      chk(tag, 128'(bus_rdata), 128'(exp));
      step(1'b0, a, '0, 1'b0, 1'b0);
   endtask

   task automatic rand_run(input int n, input logic [7:0] a);
      for (int i = 0; i < n; i++)
         step(1'b0, a, '0, ($urandom() & 1) != 0, ($urandom() & 1) != 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      m_src = 0;
      for (int k = 0; k < ND; k++) begin
         m_div[k] = 0; m_sel[k] = 0; m_act_div[k] = 0; m_act_sel[k] = 0;
         m_cnt[k] = 0; m_mask[k] = '1; tick_cnt[k] = 0; last_tick[k] = 0; gap[k] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd_lit(8'h00, 32'h0, "R1 main control after reset");
      rd_lit(8'h04, 32'h0, "R1 select word after reset");
      rd_lit(8'h08, 32'hFFFF_FFFF, "R1 cpu mask after reset");
      rd_lit(8'h0C, 32'hFFFF_FFFF, "R1 hsb mask after reset");
      rd_lit(8'h10, 32'hFFFF_FFFF, "R1 pba mask after reset");
      rd_lit(8'h14, 32'hFFFF_FFFF, "R1 pbb mask after reset");

      // R3 undivided domains follow the main tick
      pre(1'b1, 1'b0, 8'h00);
      chk("R3 undivided pulse on oscillator", 128'(dom_tick), 128'(4'hF));
      step(1'b0, 8'h00, '0, 1'b1, 1'b0);
      pre(1'b0, 1'b1, 8'h00);
      chk("R3 pll ignored while oscillator selected", 128'(dom_tick), 128'(4'h0));
      step(1'b0, 8'h00, '0, 1'b0, 1'b1);
      rand_run(100, 8'h04);

      // R2 source select
      step(1'b1, 8'h00, 32'h2, 1'b0, 1'b0);
      pre(1'b0, 1'b1, 8'h00);
      chk("R2 pll drives domains", 128'(dom_tick), 128'(4'hF));
      step(1'b0, 8'h00, '0, 1'b0, 1'b1);
      pre(1'b1, 1'b0, 8'h00);
      chk("R2 oscillator ignored", 128'(dom_tick), 128'(4'h0));
      step(1'b0, 8'h00, '0, 1'b1, 1'b0);
      rd_lit(8'h00, 32'h2, "R2 source bit readback");
      rand_run(100, 8'h00);
      step(1'b1, 8'h00, 32'h0, 1'b0, 1'b0);

      // R6 and R9 gating masks
      step(1'b1, 8'h0C, 32'h0000_A5A5, 1'b0, 1'b0);
      step(1'b1, 8'h10, 32'h0, 1'b0, 1'b0);
      pre(1'b1, 1'b0, 8'h0C);
      chk("R6 hsb enables follow mask", 128'(mod_ce[63:32]), 128'(32'h0000_A5A5));
      chk("R6 pba enables all off", 128'(mod_ce[95:64]), 128'(32'h0));
      chk("R6 cpu enables all on", 128'(mod_ce[31:0]), 128'(32'hFFFF_FFFF));
      step(1'b0, 8'h0C, '0, 1'b1, 1'b0);
      rd_lit(8'h0C, 32'h0000_A5A5, "R9 mask readback");
      step(1'b1, 8'h0C, 32'h0000_A5A5 | 32'h10, 1'b0, 1'b0);
      rd_lit(8'h0C, 32'h0000_A5B5, "R9 single bit set by read-modify-write");

      // R7 pinned enable of the controller itself
      step(1'b1, 8'h14, 32'h0, 1'b0, 1'b0);
      rd_lit(8'h14, 32'h0000_0001, "R7 own bit survives a zero write");
      pre(1'b1, 1'b0, 8'h14);
      chk("R7 own module enable still pulses", 128'(mod_ce[127:96]), 128'(32'h1));
      step(1'b0, 8'h14, '0, 1'b1, 1'b0);

      // R8 unused offsets and bits
      step(1'b1, 8'h18, 32'hFFFF_FFFF, 1'b0, 1'b0);
      step(1'b1, 8'h40, 32'h1234_5678, 1'b0, 1'b0);
      step(1'b1, 8'hFC, 32'hFFFF_FFFF, 1'b0, 1'b0);
      rd_lit(8'h18, 32'h0, "R8 unused word reads zero");
      rd_lit(8'hFC, 32'h0, "R8 top word reads zero");
      rd_lit(8'h0C, 32'h0000_A5B5, "R8 unused writes left hsb mask");
      rd_lit(8'h08, 32'hFFFF_FFFF, "R8 unused writes left cpu mask");
      rd_lit(8'h04, 32'h0, "R8 unused writes left select word");
      step(1'b1, 8'h00, 32'hFFFF_FFFD, 1'b0, 1'b0);
      rd_lit(8'h00, 32'h0, "R8 reserved control bits read zero");

      // R4 divided rates: cpu /2, hsb /4, pba /8, pbb undivided
      step(1'b1, 8'h04, 32'h0082_8180, 1'b0, 1'b0);
      rd_lit(8'h04, 32'h0082_8180, "R3 select field layout");
      for (int i = 0; i < 20; i++) step(1'b0, 8'h04, '0, 1'b1, 1'b0);
      for (int k = 0; k < ND; k++) tick_cnt[k] = 0;
      for (int i = 0; i < 64; i++) step(1'b0, 8'h04, '0, 1'b1, 1'b0);
      chk("R4 cpu pulses per 64 main ticks", 128'(tick_cnt[0]), 128'(32));
      chk("R4 hsb pulses per 64 main ticks", 128'(tick_cnt[1]), 128'(16));
      chk("R4 pba pulses per 64 main ticks", 128'(tick_cnt[2]), 128'(8));
      chk("R4 pbb pulses per 64 main ticks", 128'(tick_cnt[3]), 128'(64));
      rand_run(200, 8'h10);

      // R5 change lands mid-period of the slowest setting
      step(1'b1, 8'h04, 32'h0082_8187, 1'b1, 1'b0);
      for (int i = 0; i < 300; i++) step(1'b0, 8'h04, '0, 1'b1, 1'b0);
      n0 = tick_cnt[0];
      for (int i = 0; i < 600 && tick_cnt[0] == n0; i++) step(1'b0, 8'h04, '0, 1'b1, 1'b0);
      step(1'b1, 8'h04, 32'h0082_8180, 1'b1, 1'b0);
      n0 = tick_cnt[0];
      for (int i = 0; i < 600 && tick_cnt[0] == n0; i++) step(1'b0, 8'h04, '0, 1'b1, 1'b0);
      chk("R5 running period completes at old length", 128'(gap[0]), 128'(256));
      n0 = tick_cnt[0];
      for (int i = 0; i < 600 && tick_cnt[0] == n0; i++) step(1'b0, 8'h04, '0, 1'b1, 1'b0);
      chk("R5 new period after terminal count", 128'(gap[0]), 128'(2));

      // R8 reserved bits of the select word
      step(1'b1, 8'h04, 32'hFFFF_FFFF, 1'b0, 1'b0);
      rd_lit(8'h04, 32'h8787_8787, "R8 reserved select bits read zero");
      rand_run(300, 8'h14);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule